// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block routes a wide set of peripheral DMA request lines onto a smaller set of DMA channels. Each request line owns one map entry. An entry holds a valid flag and a target channel number. On every clock the block forwards each asserted request line to the request input of the channel its entry names, and only when that entry is valid. Several request lines may point at the same channel, and their requests then merge.

Map entries sit in two address windows. The first 64 request lines use the lower window and any further lines use the upper window. The same register port also gives access to a per-channel byte-alignment enable mask, which drives the channels directly. A read-only summary word reports which channels currently have an interrupt pending.

Top module: `req_chan_mapper`

## Requirements
- R1: After synchronous reset every map entry is invalid and reads as 0. `chan_req`, `align_en` and `reg_rdata` are all 0.
- R2: A map entry word uses bit 7 as the valid flag and bits 4:0 as the channel number. A read returns only these bits, and all other bits read 0 whatever was written.
- R3: The entry for request n < 64 is at byte address 0x100 + 4*n. The entry for request n >= 64 is at 0x1100 + 4*(n-64). An address inside a window but past the last request line, or one not word aligned, selects no entry.
- R4: When the entry for request n is valid with channel c, `chan_req[c]` is high in the cycle after `periph_req[n]` is high. With no request asserted, no channel request is asserted.
- R5: A request line whose entry has bit 7 clear drives no channel, even when its channel field is nonzero. Writing 0 to an entry removes the mapping.
- R6: When several valid entries name the same channel, that channel's request is the OR of their request lines.
- R7: A read of address 0xF0 returns `chan_irq`, with bit i set while channel i has an interrupt pending. The bit reads 0 once the channel clears its flag. Writes to 0xF0 change nothing.
- R8: Address 0xA0 is a read/write mask with bit i for channel i. Bit i drives `align_en[i]` from the cycle after the write. Writes to other addresses leave it unchanged.
- R9: `reg_rdata` carries the read data in the cycle after `reg_rd` and is 0 in any other cycle. Addresses that select nothing read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (16) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| periph_req | input | NUM_REQ (96) | Peripheral request lines |
| chan_irq | input | NUM_CH (32) | Per-channel interrupt pending flags |
| chan_req | output | NUM_CH (32) | Registered per-channel request outputs |
| align_en | output | NUM_CH (32) | Per-channel byte-alignment enable |

## Verification
The hardest case to reach from the ports is a wrong entry being selected across the window boundary. A fault in the upper-window offset or index folding could alias request 64 onto request 0 and still pass a readback test of a single entry. The stimulus therefore programs every request line with a different channel pattern, reads all of them back, and then raises each request line alone, so any aliasing or misrouting shows up as a wrong one-hot output. Merged requests, invalid entries with nonzero channel fields and holes in the upper window are then set up deliberately on top of that full table.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int CH_FIELD_W = 5;
  localparam int VLD_BIT    = 7;
  localparam int WINDOW     = 64;
  localparam int unsigned LO_BASE   = 32'h0000_0100;
  localparam int unsigned HI_BASE   = 32'h0000_1100;
  localparam int unsigned ALIGN_OFS = 32'h0000_00A0;
  localparam int unsigned SUM_OFS   = 32'h0000_00F0;

  typedef struct packed {
    logic                  vld;
    logic [CH_FIELD_W-1:0] ch;
  } map_entry_t;

  function automatic map_entry_t word_to_entry(input logic [31:0] w);
    map_entry_t e;
    e.vld = w[VLD_BIT];
    e.ch  = w[CH_FIELD_W-1:0];
    return e;
  endfunction

  function automatic logic [31:0] entry_to_word(input map_entry_t e);
    logic [31:0] w;
    w = '0;
    w[VLD_BIT] = e.vld;
    w[CH_FIELD_W-1:0] = e.ch;
    return w;
  endfunction
endpackage

// File: rtl/rcm_addr_decode.sv
module rcm_addr_decode #(
  parameter int ADDR_W  = 16,
  parameter int NUM_REQ = 96,
  parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              map_hit,
  output logic [IDX_W-1:0]  map_idx,
  output logic              align_hit,
  output logic              sum_hit
);
  import rcm_pkg::*;

  localparam int unsigned LO_CNT = (NUM_REQ < WINDOW) ? NUM_REQ : WINDOW;
  localparam int unsigned HI_CNT = (NUM_REQ > WINDOW) ? NUM_REQ - WINDOW : 0;

  int unsigned a;
  int unsigned lo_off;
  int unsigned hi_off;
  logic        word_ok;
  logic        lo_hit;
  logic        hi_hit;

  always_comb begin
    a       = 32'(addr);
    lo_off  = a - LO_BASE;
    hi_off  = a - HI_BASE;
    word_ok = (addr[1:0] == 2'b00);
    lo_hit  = word_ok && (a >= LO_BASE) && (lo_off < 4 * LO_CNT);
    hi_hit  = word_ok && (a >= HI_BASE) && (hi_off < 4 * HI_CNT);
    map_hit = lo_hit || hi_hit;
    if (hi_hit) map_idx = IDX_W'((hi_off >> 2) + WINDOW);
    else        map_idx = IDX_W'(lo_off >> 2);
    align_hit = (a == ALIGN_OFS);
    sum_hit   = (a == SUM_OFS);
  end

  always_comb begin
    if (map_hit)
      assert_idx_range_R3: assert (32'(map_idx) < NUM_REQ);
    assert_single_target_R9: assert ($onehot0({map_hit, align_hit, sum_hit}));
  end
endmodule

// File: rtl/rcm_map_table.sv
module rcm_map_table #(
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32,
  parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  rcm_pkg::map_entry_t wr_entry,
  output rcm_pkg::map_entry_t rd_entry,
  input  logic [NUM_REQ-1:0]  periph_req,
  output logic [NUM_CH-1:0]   chan_req
);
  import rcm_pkg::*;

  map_entry_t          tbl [NUM_REQ];
  logic [NUM_CH-1:0]   route_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REQ; i++) tbl[i] <= '0;
    end else if (wr_en) begin
      tbl[idx] <= wr_entry;
    end
  end

  assign rd_entry = tbl[idx];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (tbl[r].vld && (tbl[r].ch == CH_FIELD_W'(c)) && periph_req[r])
          hit = 1'b1;
      end
    end
    assign route_next[c] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst) chan_req <= '0;
    else     chan_req <= route_next;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (chan_req == '0));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (periph_req == '0) |=> (chan_req == '0));

  assert_merge_bound_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(chan_req) <= $countones($past(periph_req))));
endmodule

// File: rtl/rcm_csr.sv
module rcm_csr #(
  parameter int NUM_CH = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [31:0]         reg_wdata,
  input  logic                map_hit,
  input  logic                align_hit,
  input  logic                sum_hit,
  input  rcm_pkg::map_entry_t map_rd_entry,
  input  logic [NUM_CH-1:0]   chan_irq,
  output logic [NUM_CH-1:0]   align_en,
  output logic [31:0]         reg_rdata
);
  import rcm_pkg::*;

  logic [NUM_CH-1:0] align_q;

  always_ff @(posedge clk) begin
    if (rst)                      align_q <= '0;
    else if (reg_wr && align_hit) align_q <= reg_wdata[NUM_CH-1:0];
  end
  assign align_en = align_q;

  always_ff @(posedge clk) begin
    if (rst || !reg_rd)  reg_rdata <= '0;
    else if (map_hit)    reg_rdata <= entry_to_word(map_rd_entry);
    else if (align_hit)  reg_rdata <= 32'(align_q);
    else if (sum_hit)    reg_rdata <= 32'(chan_irq);
    else                 reg_rdata <= '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (align_en == '0 && reg_rdata == '0));

  assert_align_write_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && align_hit) |=> (align_en == $past(reg_wdata[NUM_CH-1:0])));

  assert_align_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && align_hit) |=> $stable(align_en));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

  assert_summary_read_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sum_hit) |=> (reg_rdata == 32'($past(chan_irq))));
endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper #(
  parameter int ADDR_W  = 16,
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic [NUM_CH-1:0]  chan_irq,
  output logic [NUM_CH-1:0]  chan_req,
  output logic [NUM_CH-1:0]  align_en
);
  import rcm_pkg::*;

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic             map_hit;
  logic             align_hit;
  logic             sum_hit;
  logic [IDX_W-1:0] map_idx;
  map_entry_t       map_rd_entry;

  rcm_addr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_REQ(NUM_REQ),
    .IDX_W  (IDX_W)
  ) u_decode (
    .addr     (reg_addr),
    .map_hit  (map_hit),
    .map_idx  (map_idx),
    .align_hit(align_hit),
    .sum_hit  (sum_hit)
  );

  rcm_map_table #(
    .NUM_REQ(NUM_REQ),
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr && map_hit),
    .idx       (map_idx),
    .wr_entry  (word_to_entry(reg_wdata)),
    .rd_entry  (map_rd_entry),
    .periph_req(periph_req),
    .chan_req  (chan_req)
  );

  rcm_csr #(
    .NUM_CH(NUM_CH)
  ) u_csr (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .map_hit     (map_hit),
    .align_hit   (align_hit),
    .sum_hit     (sum_hit),
    .map_rd_entry(map_rd_entry),
    .chan_irq    (chan_irq),
    .align_en    (align_en),
    .reg_rdata   (reg_rdata)
  );
endmodule

// File: tb/test_req_chan_mapper.sv
`timescale 1ns/1ps
module test_req_chan_mapper;
  localparam int NREQ = 96;
  localparam int NCH  = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NREQ-1:0] periph_req = '0;
  logic [NCH-1:0]  chan_irq = '0;
  logic [NCH-1:0]  chan_req;
  logic [NCH-1:0]  align_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  req_chan_mapper #(.ADDR_W(16), .NUM_REQ(NREQ), .NUM_CH(NCH)) i_req_chan_mapper (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .chan_irq(chan_irq), .chan_req(chan_req), .align_en(align_en));

  function automatic logic [15:0] entry_addr(input int n);
    if (n < 64) return 16'(32'h100 + 4 * n);
    else        return 16'(32'h1100 + 4 * (n - 64));
  endfunction

  function automatic int pat_ch(input int n);
    return (n * 7 + 3) % 32;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_req(input logic [NREQ-1:0] r);
    periph_req = r;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [NCH-1:0] exp_all;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 chan_req after reset", 32'(chan_req), 0);
    chk("R1 align_en after reset", 32'(align_en), 0);
    chk("R1 rdata after reset", reg_rdata, 0);
    rd(entry_addr(0), d);  chk("R1 entry 0 reset", d, 0);
    rd(entry_addr(95), d); chk("R1 entry 95 reset", d, 0);
    drive_req('1);         chk("R1 unmapped requests idle", 32'(chan_req), 0);
    drive_req('0);

    for (int n = 0; n < NREQ; n++) wr(entry_addr(n), 32'h80 | 32'(pat_ch(n)));
    for (int n = 0; n < NREQ; n++) begin
      rd(entry_addr(n), d);
      chk($sformatf("R2 R3 readback entry %0d", n), d, 32'h80 | 32'(pat_ch(n)));
    end
    for (int n = 0; n < NREQ; n++) begin
      drive_req(NREQ'(1) << n);
      chk($sformatf("R3 R4 route req %0d", n), 32'(chan_req), 32'(1) << pat_ch(n));
    end
    exp_all = '0;
    for (int n = 0; n < NREQ; n++) exp_all[pat_ch(n)] = 1'b1;
    drive_req('1);  chk("R6 all requests merged", 32'(chan_req), 32'(exp_all));
    drive_req('0);  chk("R4 requests released", 32'(chan_req), 0);

    wr(entry_addr(20), 32'hFFFF_FFFF);
    rd(entry_addr(20), d); chk("R2 reserved bits read zero", d, 32'h9F);
    drive_req(NREQ'(1) << 20); chk("R2 channel field 31", 32'(chan_req), 32'h8000_0000);

    wr(entry_addr(5), 32'h0000_001F);
    rd(entry_addr(5), d); chk("R5 invalid entry readback", d, 32'h1F);
    drive_req(NREQ'(1) << 5); chk("R5 invalid entry ignored", 32'(chan_req), 0);
    wr(entry_addr(70), 32'h0);
    rd(entry_addr(70), d); chk("R5 cleared entry readback", d, 0);
    drive_req(NREQ'(1) << 70); chk("R5 cleared entry drives nothing", 32'(chan_req), 0);

    wr(entry_addr(10), 32'h89);
    wr(entry_addr(70), 32'h89);
    drive_req(NREQ'(1) << 10); chk("R6 first source alone", 32'(chan_req), 32'h200);
    drive_req(NREQ'(1) << 70); chk("R6 second source alone", 32'(chan_req), 32'h200);
    drive_req((NREQ'(1) << 10) | (NREQ'(1) << 70));
    chk("R6 both sources", 32'(chan_req), 32'h200);
    drive_req('0); chk("R6 sources released", 32'(chan_req), 0);

    wr(16'h1180, 32'h85);
    rd(16'h1180, d); chk("R9 hole past last entry reads zero", d, 0);
    rd(entry_addr(64), d); chk("R3 R9 entry 64 untouched by hole write", d, 32'h80 | 32'(pat_ch(64)));
    wr(16'h0102, 32'h83);
    rd(16'h0102, d); chk("R3 misaligned address reads zero", d, 0);
    rd(entry_addr(0), d); chk("R3 entry 0 untouched by misaligned write", d, 32'h80 | 32'(pat_ch(0)));

    wr(16'h00A0, 32'h1234_5678);
    chk("R8 align_en after write", 32'(align_en), 32'h1234_5678);
    rd(16'h00A0, d); chk("R8 align readback", d, 32'h1234_5678);

    chan_irq = 32'hA5A5_0003;
    rd(16'h00F0, d); chk("R7 summary reflects flags", d, 32'hA5A5_0003);
    wr(16'h00F0, 32'h0);
    rd(16'h00F0, d); chk("R7 summary write ignored", d, 32'hA5A5_0003);
    chk("R8 align held across other writes", 32'(align_en), 32'h1234_5678);
    chan_irq = 32'h0000_0001;
    rd(16'h00F0, d); chk("R7 summary bits fall", d, 32'h1);
    chan_irq = '0;
    rd(16'h00F0, d); chk("R7 summary all clear", d, 0);

    reg_addr = 16'h00A0;
    @(negedge clk);
    chk("R9 rdata zero without read", reg_rdata, 0);
    rd(16'h0050, d); chk("R9 unmapped read zero", d, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule